// File: doc/BRIEF.md
# Indexed Colour Palette with Sequenced Host Loading

This block keeps a 256-entry colour table, each entry holding an 8-bit red, green and blue channel, and converts 8-bit pixel indices into packed 24-bit RGB for scanout. The host loads the table through two registers. An index register chooses the entry to write. A colour register accepts channel bytes, and an internal step counter sends each byte to the red, green or blue channel of the current entry in turn. Once the third channel is stored, the entry pointer moves to the next entry, so the host can load the whole table as one continuous stream of bytes.

The colour register accepts either a single byte or a 32-bit word. A word is split into four channel bytes and applied over four internal cycles. The host-ready output stays low while these cycles run. Any colour write raises a one-cycle change pulse, which downstream logic uses to force a full redraw. The lookup port is registered and has one cycle of latency.

Top module: `palette_port`

## Requirements
- R1: Reset asynchronously clears every entry to zero, puts the step counter on red, drives host_ready_o high and pal_changed_o low, and clears pix_rgb_o to zero.
- R2: An accepted write to offset 0 loads host_wdata_i[7:0] into the entry pointer and returns the step counter to red, even when the counter was partway through an entry.
- R3: An accepted single-byte write (host_wide_i=0) to offset 4 stores host_wdata_i[31:24] into the current step's channel (red, then green, then blue) and ignores bits 23:0.
- R4: After the blue byte is stored, the entry pointer increments modulo 256 (255 wraps to 0) and the step counter returns to red.
- R5: An accepted word write (host_wide_i=1) to offset 4 is applied as four channel bytes in the order bits 31:24, 23:16, 15:8, 7:0. These bytes continue from the current step and pointer.
- R6: After a word write is accepted, host_ready_o is low for exactly four cycles. Any write presented while host_ready_o is low is ignored.
- R7: host_rdata_o reads as zero at all times.
- R8: pix_rgb_o shows {red, green, blue} of entry pix_idx_i, with red in bits 23:16 and blue in bits 7:0, one clock after the index is presented.
- R9: If a lookup and a channel write hit the same entry in the same cycle, the lookup returns the value the entry held before the write.
- R10: pal_changed_o is high for one cycle after each accepted colour write. An index write does not raise it.
- R11: A write to any offset other than 0 and 4 changes no state and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 3 | Register byte offset |
| host_wide_i | input | 1 | 1: 32-bit word write; 0: single byte in bits 31:24 |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (always zero) |
| host_ready_o | output | 1 | Write is accepted when high |
| pix_idx_i | input | 8 | Pixel index to look up |
| pix_rgb_o | output | 24 | Registered RGB for the pixel index |
| pal_changed_o | output | 1 | One-cycle pulse after a colour write |

## Verification
The assertions check on every cycle that the step counter stays within its three legal states and that an index write always parks it on red. They also check that a word accept always drops ready on the next cycle, that a colour accept is always followed by the change pulse, that an index write never produces one, and that the pointer steps by one after blue. Other properties need whole scenarios to show them: the channel contents and byte order of word writes, the wrap from 255 to 0, the old-value result when a lookup collides with a write, and the fact that writes are dropped while busy or sent to unused offsets. The directed tasks in the bench compare these against a table kept inside the bench.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    ST_RED = 2'd0,
    ST_GRN = 2'd1,
    ST_BLU = 2'd2
  } step_e;
endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8,
  parameter int BPW    = 4,
  parameter int AW     = 3,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                wide_i,
  input  logic [BPW*CH_W-1:0] wdata_i,
  output logic                ready_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output step_e               wr_step_o,
  output logic [CH_W-1:0]     wr_byte_o,
  output logic                changed_o
);
  localparam int WORD_W = BPW * CH_W;
  localparam int CNT_W  = $clog2(BPW + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  step_e             step_q;
  logic              chg_q;
  logic accept, sel_idx, sel_map, busy, byte_vld;
  logic [CH_W-1:0] byte_val;

  assign busy     = (cnt_q != '0);
  assign ready_o  = ~busy;
  assign accept   = we_i & ready_o;
  assign sel_idx  = accept && (addr_i == AW'(IDX_OFS));
  assign sel_map  = accept && (addr_i == AW'(MAP_OFS));
  assign byte_vld = busy | (sel_map & ~wide_i);
  assign byte_val = busy ? sh_q[WORD_W-1 -: CH_W] : wdata_i[WORD_W-1 -: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sel_map && wide_i) begin
      sh_q  <= wdata_i;
      cnt_q <= CNT_W'(BPW);
    end else if (busy) begin
      sh_q  <= sh_q << CH_W;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= ST_RED;
    end else if (sel_idx) begin
      idx_q  <= wdata_i[IDX_W-1:0];
      step_q <= ST_RED;
    end else if (byte_vld) begin
      unique case (step_q)
        ST_RED:  step_q <= ST_GRN;
        ST_GRN:  step_q <= ST_BLU;
        default: begin
          step_q <= ST_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= sel_map;
  end

  assign wr_en_o   = byte_vld;
  assign wr_idx_o  = idx_q;
  assign wr_step_o = step_q;
  assign wr_byte_o = byte_val;
  assign changed_o = chg_q;

  AST_STEP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != 2'd3); // R4
  AST_IDX_PARKS_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_idx |=> (step_q == ST_RED)); // R2
  AST_BLUE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_step_o == ST_BLU && !sel_idx) |=> (wr_idx_o == $past(wr_idx_o) + 1'b1)); // R4
  AST_WORD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_map && wide_i) |=> !ready_o); // R6
  AST_IDX_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_idx |=> !changed_o); // R10
endmodule

// File: rtl/palette_ram.sv
module palette_ram
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  step_e             wr_step_i,
  input  logic [CH_W-1:0]   wr_byte_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [3*CH_W-1:0] rd_rgb_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CH_W-1:0] red_q [ENTRIES];
  logic [CH_W-1:0] grn_q [ENTRIES];
  logic [CH_W-1:0] blu_q [ENTRIES];
  logic [3*CH_W-1:0] rgb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red_q[i] <= '0;
        grn_q[i] <= '0;
        blu_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      unique case (wr_step_i)
        ST_RED:  red_q[wr_idx_i] <= wr_byte_i;
        ST_GRN:  grn_q[wr_idx_i] <= wr_byte_i;
        default: blu_q[wr_idx_i] <= wr_byte_i;
      endcase
    end
  end

  // Reads pre-edge contents: a same-cycle write is seen one lookup later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= {red_q[rd_idx_i], grn_q[rd_idx_i], blu_q[rd_idx_i]};
  end

  assign rd_rgb_o = rgb_q;
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int CH_W    = 8,
  parameter int BPW     = 4,
  parameter int AW      = 3,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_we_i,
  input  logic [AW-1:0]       host_addr_i,
  input  logic                host_wide_i,
  input  logic [BPW*CH_W-1:0] host_wdata_i,
  output logic [BPW*CH_W-1:0] host_rdata_o,
  output logic                host_ready_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*CH_W-1:0]   pix_rgb_o,
  output logic                pal_changed_o
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  step_e            wr_step;
  logic [CH_W-1:0]  wr_byte;

  assign host_rdata_o = '0;

  palette_seq #(
    .IDX_W(IDX_W), .CH_W(CH_W), .BPW(BPW), .AW(AW),
    .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .wide_i    (host_wide_i),
    .wdata_i   (host_wdata_i),
    .ready_o   (host_ready_o),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_step_o (wr_step),
    .wr_byte_o (wr_byte),
    .changed_o (pal_changed_o)
  );

  palette_ram #(.IDX_W(IDX_W), .CH_W(CH_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_step_i (wr_step),
    .wr_byte_i (wr_byte),
    .rd_idx_i  (pix_idx_i),
    .rd_rgb_o  (pix_rgb_o)
  );

  AST_MAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_ready_o && host_addr_i == AW'(MAP_OFS)) |=> pal_changed_o); // R10
  AST_BAD_OFS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i != AW'(MAP_OFS) && host_addr_i != AW'(IDX_OFS)) |=> !pal_changed_o); // R11
  AST_RGB_RESET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pix_rgb_o == '0)); // R1
endmodule

// File: tb/palette_port_tb.sv
module palette_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic        wide = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;
  logic        chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx = '0;
  int         m_step = 0;

  always #10 clk = ~clk;

  palette_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wide_i(wide), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .host_ready_o(ready), .pix_idx_i(pix), .pix_rgb_o(rgb), .pal_changed_o(chg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_byte(input logic [7:0] b);
    case (m_step)
      0: m_r[m_idx] = b;
      1: m_g[m_idx] = b;
      default: m_b[m_idx] = b;
    endcase
    if (m_step == 2) begin
      m_step = 0;
      m_idx  = m_idx + 8'd1;
    end else m_step++;
  endtask

  function automatic logic [23:0] m_rgb(input logic [7:0] p);
    return {m_r[p], m_g[p], m_b[p]};
  endfunction

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk);
    we = 1; addr = 3'd0; wide = 0; wdata = {24'hC3C3C3, v};
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R10 no pulse on index write", {31'd0, chg}, 32'd0);
    m_idx = v; m_step = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk);
    we = 1; addr = 3'd4; wide = 0; wdata = {b, 24'h5A5A5A};
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R10 pulse after byte write", {31'd0, chg}, 32'd1);
    m_byte(b);
  endtask

  task automatic wr_word(input logic [31:0] w);
    int lows;
    @(negedge clk);
    we = 1; addr = 3'd4; wide = 1; wdata = w;
    @(posedge clk);
    @(negedge clk);
    chk("R10 pulse after word write", {31'd0, chg}, 32'd1);
    // R6: index write held during busy must be ignored
    addr = 3'd0; wide = 0; wdata = 32'h0000_0077;
    lows = 0;
    while (!ready) begin
      lows++;
      @(negedge clk);
    end
    we = 0;
    chk("R6 ready low cycles", lows, 4);
    for (int k = 3; k >= 0; k--) m_byte(w[k*8 +: 8]);
  endtask

  task automatic look(input string tag, input logic [7:0] p);
    @(negedge clk);
    pix = p;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {8'd0, rgb}, {8'd0, m_rgb(p)});
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, ready}, 32'd1);
    chk("R1 changed after reset", {31'd0, chg}, 32'd0);
    chk("R1 rgb after reset", {8'd0, rgb}, 32'd0);
    look("R1 entry 0 zero", 8'd0);
    look("R1 entry 255 zero", 8'd255);
    look("R8 entry 128 zero", 8'd128);
  endtask

  task automatic t_bytes;
    wr_idx(8'd3);
    wr_byte(8'h12); wr_byte(8'h34); wr_byte(8'h56);
    wr_byte(8'hAB); wr_byte(8'hCD); wr_byte(8'hEF);
    look("R3 entry 3", 8'd3);
    look("R4 entry 4 after advance", 8'd4);
    chk("R8 red field", {24'd0, rgb[23:16]}, 32'hAB);
    chk("R8 blue field", {24'd0, rgb[7:0]}, 32'hEF);
  endtask

  task automatic t_midway;
    wr_idx(8'd40);
    wr_byte(8'h99);
    wr_idx(8'd41);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
    look("R2 entry 40 only red", 8'd40);
    look("R2 entry 41 starts at red", 8'd41);
  endtask

  task automatic t_wrap;
    wr_idx(8'd255);
    wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03);
    wr_byte(8'hF0);
    look("R4 entry 255", 8'd255);
    look("R4 wrap to entry 0", 8'd0);
  endtask

  task automatic t_word;
    wr_idx(8'd20);
    wr_word(32'h1122_3344);
    wr_word(32'h5566_7788);
    look("R5 entry 20", 8'd20);
    look("R5 entry 21", 8'd21);
    look("R5 entry 22 partial", 8'd22);
    wr_byte(8'hEE);
    look("R6 busy index write ignored", 8'd22);
  endtask

  task automatic t_collide;
    logic [23:0] old_v;
    wr_idx(8'd60);
    wr_byte(8'h10); wr_byte(8'h20);
    old_v = m_rgb(8'd60);
    @(negedge clk);
    pix = 8'd60; we = 1; addr = 3'd4; wide = 0; wdata = 32'h3000_0000;
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R9 collision returns old", {8'd0, rgb}, {8'd0, old_v});
    m_byte(8'h30);
    look("R9 new value next lookup", 8'd60);
  endtask

  task automatic t_bad_ofs;
    wr_idx(8'd70);
    @(negedge clk);
    we = 1; addr = 3'd2; wide = 1; wdata = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R11 no pulse on bad offset", {31'd0, chg}, 32'd0);
    chk("R11 ready after bad offset", {31'd0, ready}, 32'd1);
    wr_byte(8'h44);
    look("R11 pointer untouched", 8'd70);
    look("R11 entry 71 untouched", 8'd71);
  endtask

  task automatic t_rdata;
    chk("R7 rdata zero", rdata, 32'd0);
    @(negedge clk);
    we = 1; addr = 3'd4; wide = 1; wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R7 rdata zero while busy", rdata, 32'd0);
    while (!ready) @(negedge clk);
    for (int k = 0; k < 4; k++) m_byte(8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_r[i] = '0; m_g[i] = '0; m_b[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_midway();
    t_wrap();
    t_word();
    t_collide();
    t_bad_ofs();
    t_rdata();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule